// File: doc/BRIEF.md
# Second-Order One-Bit Delta-Sigma Modulator

This block is a synthesizable digital model of a second-order delta-sigma modulator. Each modulator clock it takes a signed 16-bit sample that represents a differential voltage and produces one output bit. Over time the fraction of ones in the stream follows the input: a zero input gives half ones, the positive full-scale input gives all ones and the negative full-scale input gives all zeros. The loop has two cascaded saturating integrators, and the quantized bit is fed back into both of them.

The block serves as a stimulus source or as a loopback reference for the decimation filters further down the chain. A clock enable gates the loop, so the bit rate can be a fraction of the system clock. A strobe marks every cycle in which a fresh bit has been launched.

Top module: `dsm2_mod`

## Requirements
- R1: Each enabled rising edge registers a new bit. `bit_out` becomes 1 exactly when the updated second integrator is zero or positive, and becomes 0 when it is negative.
- R2: `x_in` is two's complement, and +32767 / -32767 stand for positive / negative full scale. The first integrator adds `x_in` minus the feedback level. The second integrator adds the first integrator's current value minus twice the feedback level. The feedback level is +32767 when `bit_out` is 1 and -32767 when it is 0.
- R3: For any constant input x with magnitude up to 26000, the ones counted over N bits after a 64-bit settling run equal N*(32767+x)/65534 within 8. A zero input therefore gives 50% ones.
- R4: An input of +20480 gives 81.25% ones (3328 of 4096), and -20480 gives 18.75% (768 of 4096), each within 8.
- R5: An input of +25600 gives about 89.06% ones (3648 of 4096), and -25600 gives about 10.94% (448 of 4096), each within 8.
- R6: A constant +32767 gives only ones after 16 settling bits, and a constant -32767 gives only zeros after 16 settling bits, each over 4000 bits.
- R7: Both integrators are 24 bits wide and clamp at their signed limits instead of wrapping. A first-integrator step never leaves [-65535, 65534]. Holding -32767 drives the second integrator to its lower limit, and the stream stays all zeros.
- R8: While `rst_n` is low, `bit_out`, `bit_vld` and both integrators are 0. The reset is asynchronous and its release is synchronous.
- R9: While `en` is low, both integrators and `bit_out` hold their values. The bits launched under any enable pattern equal, in order, the bits of an uninterrupted run with the same input.
- R10: `bit_vld` is 1 in the cycle after an edge at which `en` was 1, and 0 in the cycle after an edge at which `en` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| en | input | 1 | Clock enable for the loop |
| x_in | input | 16 | Signed input sample, ±32767 = ±full scale |
| bit_out | output | 1 | Registered modulator bit |
| bit_vld | output | 1 | High when a new bit was launched at the last edge |

## Verification
The bench builds the block with its default widths: a 16-bit input and 24-bit integrators. With these widths the full-scale input saturates the second integrator within about 130 cycles, so the clamp behaviour can be reached in a short run. A sweep across 27 DC levels, from -26000 to +26000 in steps of 2000, compares the ones count against the arithmetic density. The nominal operating points and both full-scale rails are tested separately. A gated-enable run is compared bit for bit against an ungated run of the same input.

// File: rtl/dsm2_pkg.sv
`timescale 1ns/1ps
package dsm2_pkg;
  // extra sum bits so that a + b - c of ACC_W-bit terms cannot overflow before clamping
  localparam int DSM2_GUARD = 2;

  typedef enum logic {
    DSM2_NEG = 1'b0,
    DSM2_POS = 1'b1
  } dsm2_level_e;
endpackage

// File: rtl/dsm2_integrator.sv
`timescale 1ns/1ps
module dsm2_integrator
  import dsm2_pkg::*;
#(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] add_i,
  input  logic signed [ACC_W-1:0] sub_i,
  output logic signed [ACC_W-1:0] acc_o,
  output logic signed [ACC_W-1:0] acc_nxt_o
);
  localparam int SUM_W = ACC_W + DSM2_GUARD;
  localparam logic signed [SUM_W-1:0] LIM_HI = {{(DSM2_GUARD+1){1'b0}}, {(ACC_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LIM_LO = {{(DSM2_GUARD+1){1'b1}}, {(ACC_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum_w;

  // next-state: wide sum, then clamp to the accumulator range
  always_comb begin
    sum_w = SUM_W'(acc_o) + SUM_W'(add_i) - SUM_W'(sub_i);
    if (sum_w > LIM_HI) begin
      acc_nxt_o = LIM_HI[ACC_W-1:0];
    end else if (sum_w < LIM_LO) begin
      acc_nxt_o = LIM_LO[ACC_W-1:0];
    end else begin
      acc_nxt_o = sum_w[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_o <= '0;
    end else if (en) begin
      acc_o <= acc_nxt_o;
    end
  end
endmodule

// File: rtl/dsm2_quantizer.sv
`timescale 1ns/1ps
module dsm2_quantizer
  import dsm2_pkg::*;
#(
  parameter int ACC_W = 24,
  parameter int FS    = 32767
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] loop_nxt_i,
  output logic                    bit_o,
  output logic                    vld_o,
  output logic signed [ACC_W-1:0] fb1_o,
  output logic signed [ACC_W-1:0] fb2_o
);
  localparam logic signed [ACC_W-1:0] LVL1 = ACC_W'(FS);
  localparam logic signed [ACC_W-1:0] LVL2 = ACC_W'(2 * FS);

  dsm2_level_e dec_nxt;
  dsm2_level_e dec_q;

  always_comb begin
    dec_nxt = loop_nxt_i[ACC_W-1] ? DSM2_NEG : DSM2_POS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= DSM2_NEG;
      vld_o <= 1'b0;
    end else begin
      vld_o <= en;
      if (en) begin
        dec_q <= dec_nxt;
      end
    end
  end

  // feedback levels follow the bit currently on the output
  always_comb begin
    bit_o = (dec_q == DSM2_POS);
    fb1_o = bit_o ? LVL1 : -LVL1;
    fb2_o = bit_o ? LVL2 : -LVL2;
  end
endmodule

// File: rtl/dsm2_mod.sv
`timescale 1ns/1ps
module dsm2_mod #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [IN_W-1:0] x_in,
  output logic            bit_out,
  output logic            bit_vld
);
  localparam int FS = (2 ** (IN_W - 1)) - 1;

  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] acc1;
  logic signed [ACC_W-1:0] acc1_nxt;
  logic signed [ACC_W-1:0] acc2;
  logic signed [ACC_W-1:0] acc2_nxt;
  logic signed [ACC_W-1:0] fb1;
  logic signed [ACC_W-1:0] fb2;

  always_comb begin
    x_ext = {{(ACC_W-IN_W){x_in[IN_W-1]}}, x_in};
  end

  // stage 1: input minus feedback
  dsm2_integrator #(.ACC_W(ACC_W)) int1_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .add_i     (x_ext),
    .sub_i     (fb1),
    .acc_o     (acc1),
    .acc_nxt_o (acc1_nxt)
  );

  // stage 2: stage-1 state minus doubled feedback
  dsm2_integrator #(.ACC_W(ACC_W)) int2_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .add_i     (acc1),
    .sub_i     (fb2),
    .acc_o     (acc2),
    .acc_nxt_o (acc2_nxt)
  );

  dsm2_quantizer #(.ACC_W(ACC_W), .FS(FS)) quant_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .loop_nxt_i (acc2_nxt),
    .bit_o      (bit_out),
    .vld_o      (bit_vld),
    .fb1_o      (fb1),
    .fb2_o      (fb2)
  );
endmodule

// File: rtl/dsm2_mod_chk.sv
`timescale 1ns/1ps
module dsm2_mod_chk #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en,
  input logic [IN_W-1:0]         x_in,
  input logic                    bit_out,
  input logic                    bit_vld,
  input logic signed [ACC_W-1:0] acc1,
  input logic signed [ACC_W-1:0] acc2
);
  localparam int FS = (2 ** (IN_W - 1)) - 1;
  localparam int STEP_HI = FS + FS;
  localparam int STEP_LO = -(FS + FS + 1);

  logic [IN_W-1:0] x_unused;
  always_comb x_unused = x_in;

  // R1: launched bit agrees with the sign of the second integrator
  a_r1_bit_sign: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (bit_out == !acc2[ACC_W-1]));

  // R7: one step of the first integrator stays inside the input-minus-feedback span
  a_r7_step_span: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (($signed(acc1) - $past($signed(acc1))) <= STEP_HI) &&
           (($signed(acc1) - $past($signed(acc1))) >= STEP_LO));

  // R8: state seen at reset release is cleared
  a_r8_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> (!bit_out && !bit_vld && acc1 == '0 && acc2 == '0));

  // R9: disabled cycles freeze state and output
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(bit_out) && $stable(acc1) && $stable(acc2)));

  // R10: strobe follows enable by one edge
  a_r10_vld_on: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> bit_vld);

  a_r10_vld_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bit_vld);
endmodule

bind dsm2_mod dsm2_mod_chk #(.IN_W(IN_W), .ACC_W(ACC_W)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .x_in    (x_in),
  .bit_out (bit_out),
  .bit_vld (bit_vld),
  .acc1    (acc1),
  .acc2    (acc2)
);

// File: tb/dsm2_mod_tb_top.sv
`timescale 1ns/1ps
module dsm2_mod_tb_top;
  localparam int IN_W = 16;
  localparam int FS   = 32767;
  localparam int TOL  = 8;
  localparam int REF_N = 300;

  logic            clk;
  logic            rst_n;
  logic            en;
  logic [IN_W-1:0] x_in;
  logic            bit_out;
  logic            bit_vld;

  int n_checks;
  int n_fail;
  bit done;
  bit ref_bits [REF_N];

  dsm2_mod dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .x_in    (x_in),
    .bit_out (bit_out),
    .bit_vld (bit_vld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en    = 1'b0;
    x_in  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic count_ones(input int x, input int settle, input int n, output int ones);
    x_in = IN_W'(x);
    en   = 1'b1;
    repeat (settle) @(negedge clk);
    ones = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ones += int'(bit_out);
    end
    en = 1'b0;
  endtask

  function automatic int ideal_ones(input int x, input int n);
    real r;
    r = (real'(n) * real'(FS + x)) / real'(2 * FS);
    return int'(r);
  endfunction

  task automatic density_check(input int x, input int n, input string req);
    int ones;
    int exp;
    do_reset();
    count_ones(x, 64, n, ones);
    exp = ideal_ones(x, n);
    check((ones - exp <= TOL) && (exp - ones <= TOL), req, ones, exp);
  endtask

  initial begin
    int ones;
    int idx;
    int mism;
    int hold_err;
    int vld_err;
    bit last_bit;
    bit en_prev;
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    en       = 1'b0;
    x_in     = '0;

    // R8: reset state
    repeat (2) @(negedge clk);
    check(bit_out == 1'b0, "R8 bit_out in reset", int'(bit_out), 0);
    check(bit_vld == 1'b0, "R8 bit_vld in reset", int'(bit_vld), 0);

    // R3: zero input gives half ones
    density_check(0, 4096, "R3 zero input 50%");
    // R4: nominal operating points
    density_check(20480, 4096, "R4 +20480 81.25%");
    density_check(-20480, 4096, "R4 -20480 18.75%");
    check(ideal_ones(20480, 4096) == 3328, "R4 density arithmetic", ideal_ones(20480, 4096), 3328);
    // R5: wider operating points
    density_check(25600, 4096, "R5 +25600 89.06%");
    density_check(-25600, 4096, "R5 -25600 10.94%");

    // R3 / R2: DC sweep
    for (int x = -26000; x <= 26000; x += 2000) begin
      density_check(x, 2048, $sformatf("R3 sweep x=%0d", x));
    end

    // R6: positive full scale, all ones
    do_reset();
    count_ones(FS, 16, 4000, ones);
    check(ones == 4000, "R6 +full scale all ones", ones, 4000);

    // R6 / R7: negative full scale, all zeros while the second integrator sits at its clamp
    do_reset();
    count_ones(-FS, 16, 4000, ones);
    check(ones == 0, "R6 R7 -full scale all zeros", ones, 0);

    // R9 / R10: reference run without gaps
    do_reset();
    x_in = IN_W'(12345);
    en   = 1'b1;
    for (int k = 0; k < REF_N; k++) begin
      @(negedge clk);
      ref_bits[k] = bit_out;
    end
    en = 1'b0;

    do_reset();
    x_in = IN_W'(12345);
    check(bit_vld == 1'b0, "R10 strobe low while idle", int'(bit_vld), 0);
    idx      = 0;
    mism     = 0;
    hold_err = 0;
    vld_err  = 0;
    last_bit = bit_out;
    for (int k = 0; idx < REF_N && k < 2000; k++) begin
      en_prev = ((k % 3) != 1) && ((k % 7) != 5);
      en = en_prev;
      @(negedge clk);
      if (bit_vld != en_prev) vld_err++;
      if (en_prev) begin
        if (bit_out != ref_bits[idx]) mism++;
        idx++;
      end else begin
        if (bit_out != last_bit) hold_err++;
      end
      last_bit = bit_out;
    end
    en = 1'b0;
    check(idx == REF_N, "R9 gated run length", idx, REF_N);
    check(mism == 0, "R9 gated stream matches ungated", mism, 0);
    check(hold_err == 0, "R9 bit holds while disabled", hold_err, 0);
    check(vld_err == 0, "R10 strobe follows enable", vld_err, 0);

    // R8: asynchronous reset mid-stream
    x_in = IN_W'(FS);
    en   = 1'b1;
    repeat (20) @(negedge clk);
    #2 rst_n = 1'b0;
    #1;
    check(bit_out == 1'b0, "R8 async clear of bit", int'(bit_out), 0);
    check(bit_vld == 1'b0, "R8 async clear of strobe", int'(bit_vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    en    = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule